// File: doc/BRIEF.md
# Grouped In-Order Retirement Buffer

This block is a circular reorder buffer that sits between instruction dispatch and the architectural register file. Each cycle, dispatch may place up to three micro-operations into the buffer in program order. For each one the buffer hands back the slot index it was given. Execution units later report results against that index, in any order. The buffer then commits finished work from the oldest end. It writes each result into an eight-entry, 32-bit architectural register file and frees the slots.

Micro-operations are grouped into parent instructions. A flag on the final micro-operation of each parent closes the group. A group commits as a whole or not at all. When the next group would not fit inside the three-per-cycle retirement width, retirement stops at the boundary of the last whole group and commits the rest in a later cycle. A single-cycle clear empties the buffer and leaves the committed registers as they were.

Top module: `grp_retire_rob`

## Requirements
- R1: After reset the buffer is empty, slot 0 of the allocation index bus reads 0, `ret_cnt` is 0 and all eight architectural registers read 0.
- R2: A request for n (0 to 3) micro-operations that fits in the free space is accepted (`alloc_ok`=1). The slots are consecutive and start at the current tail. Slot k's index is on `alloc_idx[6k+5:6k]`, and slot k takes `alloc_dst[3k+2:3k]` and `alloc_last[k]`.
- R3: A request larger than the free slots (40 minus occupancy) is refused (`alloc_ok`=0). Nothing is written and the tail does not move.
- R4: A completion report (`cpl_vld`, `cpl_idx`, `cpl_data`) marks that slot executed and stores its result, whatever the order of reports.
- R5: Retirement is strictly oldest-first. Nothing commits while the oldest occupied slot is unexecuted.
- R6: Up to three micro-operations commit per cycle. `ret_cnt` gives how many commit at the next clock edge, and `ret_dst`/`ret_data` list them oldest first.
- R7: A group commits only when all its micro-operations are executed. If the retirement width would split a group, retirement stops at the previous group boundary.
- R8: Commits update the architectural registers at the clock edge. Within one cycle a younger write to the same register wins.
- R9: `flush` empties the buffer in one cycle and resets both pointers to slot 0. No register is written, and allocation is refused during that cycle.
- R10: Slot indices wrap from 39 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all entries in one cycle |
| alloc_req | input | 2 | Number of micro-operations to allocate (0..3) |
| alloc_dst | input | 9 | Destination register per slot, 3 bits each |
| alloc_last | input | 3 | Last-of-group flag per slot |
| alloc_ok | output | 1 | Request accepted this cycle |
| alloc_idx | output | 18 | Assigned slot index per slot, 6 bits each |
| cpl_vld | input | 1 | Completion report valid |
| cpl_idx | input | 6 | Slot index being completed |
| cpl_data | input | 32 | Result value |
| ret_cnt | output | 2 | Number committing at the next edge |
| ret_dst | output | 9 | Destination registers of committing entries |
| ret_data | output | 96 | Results of committing entries |
| rd_sel | input | 3 | Architectural register read select |
| rd_data | output | 32 | Architectural register value |

## Verification
`alloc_ok` and `alloc_idx` are combinational, so the bench samples them 1 ns after it drives a request. A completion is registered at the next edge. From the falling edge after that edge, `ret_cnt`, `ret_dst` and `ret_data` already show the commit it made possible. The register file shows that commit one full cycle later, when the next falling edge is sampled. Each task drives on a falling edge and samples only at these falling-edge points.

// File: rtl/grob_pkg.sv
package grob_pkg;
  // Circular increment of a slot pointer
  function automatic int ring_add(input int p, input int d, input int depth);
    int s;
    s = p + d;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/grob_ptr_ctl.sv
module grob_ptr_ctl #(
  parameter int DEPTH = 40,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6,
  parameter int N_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [N_W-1:0]   alloc_n,
  input  logic [N_W-1:0]   ret_n,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= IDX_W'(grob_pkg::ring_add(int'(head), int'(ret_n), DEPTH));
      tail  <= IDX_W'(grob_pkg::ring_add(int'(tail), int'(alloc_n), DEPTH));
      count <= count + CNT_W'(alloc_n) - CNT_W'(ret_n);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && head == '0 && tail == '0)); // R9
endmodule

// File: rtl/grob_retire_sel.sv
module grob_retire_sel #(
  parameter int DEPTH = 40,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6,
  parameter int RET_W = 3,
  parameter int N_W   = 2
) (
  input  logic [IDX_W-1:0]       head,
  input  logic [CNT_W-1:0]       count,
  input  logic [DEPTH-1:0]       exec_vec,
  input  logic [DEPTH-1:0]       last_vec,
  output logic [N_W-1:0]         ret_n,
  output logic [RET_W*IDX_W-1:0] ret_slot
);
  // Longest ready prefix from the head that ends on a group boundary
  always_comb begin
    logic ok;
    int   s;
    ok    = 1'b1;
    ret_n = '0;
    ret_slot = '0;
    for (int i = 0; i < RET_W; i++) begin
      s = grob_pkg::ring_add(int'(head), i, DEPTH);
      ret_slot[i*IDX_W +: IDX_W] = IDX_W'(s);
      ok = ok && (i < int'(count)) && exec_vec[s];
      if (ok && last_vec[s]) ret_n = N_W'(i + 1);
    end
  end
endmodule

// File: rtl/grob_arch_regs.sv
module grob_arch_regs #(
  parameter int NREG   = 8,
  parameter int DATA_W = 32,
  parameter int RET_W  = 3,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RET_W-1:0]        we,
  input  logic [RET_W*RA_W-1:0]   waddr,
  input  logic [RET_W*DATA_W-1:0] wdata,
  input  logic [RA_W-1:0]         rd_sel,
  output logic [DATA_W-1:0]       rd_data
);
  logic [NREG*DATA_W-1:0] regs_q;

  // Ascending order: the youngest write to a register lands last
  always_ff @(posedge clk) begin
    if (!rst_n) regs_q <= '0;
    else
      for (int i = 0; i < RET_W; i++)
        if (we[i])
          regs_q[int'(waddr[i*RA_W +: RA_W])*DATA_W +: DATA_W] <= wdata[i*DATA_W +: DATA_W];
  end

  assign rd_data = regs_q[int'(rd_sel)*DATA_W +: DATA_W];

  AST_ARCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(regs_q)); // R9
endmodule

// File: rtl/grp_retire_rob.sv
module grp_retire_rob #(
  parameter int DEPTH   = 40,
  parameter int ALLOC_W = 3,
  parameter int RET_W   = 3,
  parameter int NREG    = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RA_W   = $clog2(NREG),
  localparam int AQ_W   = $clog2(ALLOC_W + 1),
  localparam int RQ_W   = $clog2(RET_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [AQ_W-1:0]           alloc_req,
  input  logic [ALLOC_W*RA_W-1:0]   alloc_dst,
  input  logic [ALLOC_W-1:0]        alloc_last,
  output logic                      alloc_ok,
  output logic [ALLOC_W*IDX_W-1:0]  alloc_idx,
  input  logic                      cpl_vld,
  input  logic [IDX_W-1:0]          cpl_idx,
  input  logic [DATA_W-1:0]         cpl_data,
  output logic [RQ_W-1:0]           ret_cnt,
  output logic [RET_W*RA_W-1:0]     ret_dst,
  output logic [RET_W*DATA_W-1:0]   ret_data,
  input  logic [RA_W-1:0]           rd_sel,
  output logic [DATA_W-1:0]         rd_data
);
  localparam int N_W = (AQ_W > RQ_W) ? AQ_W : RQ_W;

  logic [RA_W-1:0]   dst_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  exec_q, last_q;

  logic [IDX_W-1:0]       head, tail;
  logic [CNT_W-1:0]       count, free_slots;
  logic [N_W-1:0]         alloc_n, ret_n_sel, ret_n;
  logic [RET_W*IDX_W-1:0] ret_slot;
  logic [RET_W-1:0]       ret_we;
  logic                   oldest_exec, final_last;

  // Allocation: fits only if the whole request fits
  assign free_slots = CNT_W'(DEPTH) - count;
  assign alloc_ok   = !flush && (CNT_W'(alloc_req) <= free_slots);
  assign alloc_n    = alloc_ok ? N_W'(alloc_req) : '0;

  for (genvar g = 0; g < ALLOC_W; g++) begin : g_aidx
    assign alloc_idx[g*IDX_W +: IDX_W] = IDX_W'(grob_pkg::ring_add(int'(tail), g, DEPTH));
  end

  grob_ptr_ctl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .N_W(N_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_n(alloc_n), .ret_n(ret_n),
    .head(head), .tail(tail), .count(count)
  );

  grob_retire_sel #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .RET_W(RET_W),
                    .N_W(N_W)) u_sel (
    .head(head), .count(count), .exec_vec(exec_q), .last_vec(last_q),
    .ret_n(ret_n_sel), .ret_slot(ret_slot)
  );

  assign ret_n   = flush ? '0 : ret_n_sel;
  assign ret_cnt = RQ_W'(ret_n);

  for (genvar g = 0; g < RET_W; g++) begin : g_ret
    assign ret_we[g] = (g < int'(ret_n));
    assign ret_dst[g*RA_W +: RA_W]     = dst_q[int'(ret_slot[g*IDX_W +: IDX_W])];
    assign ret_data[g*DATA_W +: DATA_W] = data_q[int'(ret_slot[g*IDX_W +: IDX_W])];
  end

  // Entry storage: completion first, allocation of a fresh slot overrides
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      exec_q <= '0;
      last_q <= '0;
    end else begin
      if (cpl_vld) begin
        exec_q[cpl_idx] <= 1'b1;
        data_q[cpl_idx] <= cpl_data;
      end
      for (int i = 0; i < ALLOC_W; i++)
        if (i < int'(alloc_n)) begin
          exec_q[alloc_idx[i*IDX_W +: IDX_W]] <= 1'b0;
          last_q[alloc_idx[i*IDX_W +: IDX_W]] <= alloc_last[i];
          dst_q[alloc_idx[i*IDX_W +: IDX_W]]  <= alloc_dst[i*RA_W +: RA_W];
          data_q[alloc_idx[i*IDX_W +: IDX_W]] <= '0;
        end
    end
  end

  grob_arch_regs #(.NREG(NREG), .DATA_W(DATA_W), .RET_W(RET_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(ret_we), .waddr(ret_dst), .wdata(ret_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // Named events for the checks below
  assign oldest_exec = exec_q[head];
  always_comb begin
    final_last = 1'b0;
    for (int i = 0; i < RET_W; i++)
      if (i + 1 == int'(ret_n)) final_last = last_q[ret_slot[i*IDX_W +: IDX_W]];
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req != '0 && !alloc_ok && !flush) |=> $stable(tail)); // R3
  AST_RET_OLDEST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n != '0) |-> oldest_exec); // R5
  AST_GROUP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n != '0) |-> final_last); // R7
  AST_RET_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_n != '0) |-> (CNT_W'(ret_n) <= count)); // R6
endmodule

// File: tb/grp_retire_rob_tb_top.sv
`timescale 1ns/1ps
module grp_retire_rob_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [1:0] alloc_req = '0;
  logic [8:0] alloc_dst = '0;
  logic [2:0] alloc_last = '0;
  logic alloc_ok;
  logic [17:0] alloc_idx;
  logic cpl_vld = 1'b0;
  logic [5:0] cpl_idx = '0;
  logic [31:0] cpl_data = '0;
  logic [1:0] ret_cnt;
  logic [8:0] ret_dst;
  logic [95:0] ret_data;
  logic [2:0] rd_sel = '0;
  logic [31:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int tail_m = 0;
  logic [31:0] sh [8];
  bit done = 0;

  always #4 clk = ~clk;

  grp_retire_rob dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_req(alloc_req),
    .alloc_dst(alloc_dst), .alloc_last(alloc_last), .alloc_ok(alloc_ok),
    .alloc_idx(alloc_idx), .cpl_vld(cpl_vld), .cpl_idx(cpl_idx),
    .cpl_data(cpl_data), .ret_cnt(ret_cnt), .ret_dst(ret_dst),
    .ret_data(ret_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrap(input int v);
    return v % 40;
  endfunction

  task automatic cycle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      rd_sel = 3'(r); #1;
      chk(rd_data == sh[r], req, rd_data, sh[r]);
    end
  endtask

  // Drive a request, check acceptance and indices, commit it at the edge
  task automatic do_alloc(input int n, input int d0, input int d1, input int d2,
                          input logic [2:0] last, input bit exp_ok);
    alloc_req = 2'(n);
    alloc_dst = {3'(d2), 3'(d1), 3'(d0)};
    alloc_last = last;
    #1;
    chk(alloc_ok == exp_ok, exp_ok ? "R2" : "R3", alloc_ok, exp_ok);
    for (int k = 0; k < n; k++) begin
      chk(alloc_idx[k*6 +: 6] == 6'(wrap(tail_m + k)), "R2", alloc_idx[k*6 +: 6], wrap(tail_m + k));
      if (tail_m + k == 40) chk(alloc_idx[k*6 +: 6] == 6'd0, "R10", alloc_idx[k*6 +: 6], 0);
    end
    cycle();
    alloc_req = '0;
    if (exp_ok) tail_m = wrap(tail_m + n);
  endtask

  task automatic do_cpl(input int idx, input logic [31:0] d);
    cpl_vld = 1'b1; cpl_idx = 6'(idx); cpl_data = d;
    cycle();
    cpl_vld = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk(ret_cnt == 0, "R1", ret_cnt, 0);
    chk(alloc_idx[5:0] == 0, "R1", alloc_idx[5:0], 0);
    check_regs("R1");
  endtask

  task automatic t_inorder();
    int b;
    b = tail_m;
    do_alloc(3, 1, 1, 2, 3'b111, 1);
    do_cpl(wrap(b + 2), 32'd33);
    chk(ret_cnt == 0, "R5", ret_cnt, 0);
    do_cpl(wrap(b + 1), 32'd22);
    chk(ret_cnt == 0, "R4", ret_cnt, 0);
    do_cpl(b, 32'd11);
    chk(ret_cnt == 3, "R6", ret_cnt, 3);
    chk(ret_data[31:0] == 32'd11, "R6", ret_data[31:0], 11);
    chk(ret_dst[8:6] == 3'd2, "R6", ret_dst[8:6], 2);
    cycle();
    sh[1] = 32'd22; sh[2] = 32'd33;
    check_regs("R8");
  endtask

  task automatic t_group();
    int b;
    b = tail_m;
    do_alloc(3, 3, 4, 5, 3'b110, 1);
    do_cpl(b, 32'd100);
    chk(ret_cnt == 0, "R7", ret_cnt, 0);
    do_cpl(wrap(b + 2), 32'd102);
    chk(ret_cnt == 0, "R7", ret_cnt, 0);
    do_cpl(wrap(b + 1), 32'd101);
    chk(ret_cnt == 3, "R7", ret_cnt, 3);
    cycle();
    sh[3] = 32'd100; sh[4] = 32'd101; sh[5] = 32'd102;
    b = tail_m;
    do_alloc(3, 6, 7, 0, 3'b001, 1);
    do_alloc(1, 7, 0, 0, 3'b001, 1);
    do_cpl(wrap(b + 3), 32'd203);
    do_cpl(wrap(b + 2), 32'd202);
    do_cpl(wrap(b + 1), 32'd201);
    chk(ret_cnt == 0, "R5", ret_cnt, 0);
    do_cpl(b, 32'd200);
    chk(ret_cnt == 1, "R7", ret_cnt, 1);
    cycle();
    chk(ret_cnt == 3, "R7", ret_cnt, 3);
    cycle();
    sh[6] = 32'd200; sh[7] = 32'd203; sh[0] = 32'd202;
    check_regs("R8");
  endtask

  task automatic t_fill_flush();
    int b;
    b = tail_m;
    for (int j = 0; j < 13; j++) do_alloc(3, 0, 0, 0, 3'b111, 1);
    do_alloc(3, 0, 0, 0, 3'b111, 0);
    do_alloc(1, 0, 0, 0, 3'b001, 1);
    do_alloc(1, 0, 0, 0, 3'b001, 0);
    do_cpl(wrap(b + 1), 32'hdead);
    chk(ret_cnt == 0, "R5", ret_cnt, 0);
    flush = 1'b1;
    cycle();
    flush = 1'b0;
    tail_m = 0;
    #1;
    chk(ret_cnt == 0, "R9", ret_cnt, 0);
    check_regs("R9");
    do_alloc(3, 1, 2, 3, 3'b111, 1);
    do_cpl(0, 32'd7); do_cpl(1, 32'd8); do_cpl(2, 32'd9);
    cycle();
    sh[1] = 32'd7; sh[2] = 32'd8; sh[3] = 32'd9;
    check_regs("R8");
  endtask

  initial begin
    for (int r = 0; r < 8; r++) sh[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_inorder();
    t_group();
    t_fill_flush();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule